// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time against a single-port memory. For each command it takes a base register value, a signed 16-bit byte offset, a source register value, the current value of register 0, an operation code and a size select (32-bit or 64-bit word). It reads the addressed word, computes the new word, and writes it back when the operation calls for a write. When the command finishes, the unit reports the value and the register index that the register file must write.

The supported operations are add, or, and and xor, each with a non-fetching form and a fetching form. The unit also supports unconditional exchange and compare-and-swap. Compare-and-swap always uses register 0 as the comparand, and it always returns the old word to register 0. An older add encoding is accepted as a plain add. The unit accepts no new command until it reaches its completion cycle. A command with a misaligned address or an unknown opcode completes with an error flag and makes no memory access.

Top module: `amo_unit`

## Requirements
- R1: The memory address is `base` plus `ofs` sign-extended to the address width. The same address is used for both the read and the write of a command.
- R2: Opcodes 0 (add), 1 (or), 2 (and) and 3 (xor) write back to memory the old word combined with the source value by that operation. In their completion cycle `wb_en` is 0.
- R3: Opcodes 4 to 7 (fetching add, or, and, xor) make the same memory update as opcodes 0 to 3. They also return the old word on `wb_data` with `wb_en`=1 and `wb_reg`=`src_idx`.
- R4: Opcode 8 (exchange) writes the source value to memory. It returns the old word to `src_idx`.
- R5: Opcode 9 (compare-and-swap) writes the source value to memory only when the old word equals `r0_val`. On a mismatch no write request is issued, and the command completes one cycle after the computation cycle.
- R6: Every compare-and-swap, whether it matches or not, completes with `wb_en`=1, `wb_reg`=0 and `wb_data` equal to the old word zero-extended.
- R7: When `wide`=0 the access is a 32-bit word and `mem_size`=0. Arithmetic wraps at 32 bits and the comparison uses only the low 32 bits. Write data and the write-back value have their upper 32 bits at zero.
- R8: Opcode 10 (older add encoding) behaves exactly like opcode 0, in both sizes.
- R9: After `start` is taken in the idle state, the unit makes one read request, then spends one computation cycle, then makes one write request if the operation needs it. `done` pulses for one cycle after the last handshake. `mem_req` is held with a steady address until `mem_ready`. A `start` that arrives while `busy`=1 is ignored.
- R10: An address that is not a multiple of 8 (when `wide`=1) or of 4 (when `wide`=0) completes one cycle after `start` with `done`=1, `err`=1 and `wb_en`=0. No memory request is made.
- R11: Any opcode above 10 completes in the same way as R10, with an error and no memory access.
- R12: While reset is asserted, and after it is released, the unit is idle: `busy`, `done`, `mem_req` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| op | input | 4 | Operation code (0..10 legal) |
| wide | input | 1 | 1 = 64-bit word, 0 = 32-bit word |
| base | input | 64 | Base register value |
| ofs | input | 16 | Signed byte offset |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register 0 value (compare-and-swap comparand) |
| src_idx | input | 4 | Index of the source register |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Completion with alignment or opcode error |
| wb_en | output | 1 | Register write-back valid (with `done`) |
| wb_reg | output | 4 | Register index to write |
| wb_data | output | 64 | Value to write to that register |
| mem_req | output | 1 | Memory request, held until `mem_ready` |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_size | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data (32-bit data in low half) |
| mem_rdata | input | 64 | Read data, valid with `mem_ready` on a read |
| mem_ready | input | 1 | Handshake completion |

## Verification
With a memory that adds L wait cycles, the timing of a legal command is fixed, counting in negedges after the edge that takes `start`. The read request is seen in cycles 1 to 1+L and the computation cycle is 2+L. The write request, when there is one, occupies cycles 3+L to 3+2L. `done` falls in cycle 4+2L, or in cycle 3+L when no write is made. An error command shows `done` in cycle 1. The bench derives this timeline from its own model and compares `mem_req`, `mem_we` and `done` against it at every negedge. It checks write-back values in the `done` cycle and memory contents one cycle later, after the write has been committed. Runs with L of 0, 1 and 2 confirm that the timeline moves with the wait states.

// File: rtl/amo_pkg.sv
package amo_pkg;

  // Operation codes; ordering matters only in that all legal codes are <= AMO_LADD
  localparam int AMO_ADD  = 0;
  localparam int AMO_OR   = 1;
  localparam int AMO_AND  = 2;
  localparam int AMO_XOR  = 3;
  localparam int AMO_FADD = 4;
  localparam int AMO_FOR  = 5;
  localparam int AMO_FAND = 6;
  localparam int AMO_FXOR = 7;
  localparam int AMO_XCHG = 8;
  localparam int AMO_CAS  = 9;
  localparam int AMO_LADD = 10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_CALC  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } amo_state_e;

endpackage

// File: rtl/amo_addr_gen.sv
module amo_addr_gen #(
  parameter int ADDR_W = 64,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext    = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    addr       = base + ofs_ext;
    misaligned = wide ? (addr[2:0] != 3'b000) : (addr[1:0] != 2'b00);
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OP_W   = 4,
  parameter int RIDX_W = 4
) (
  input  logic [OP_W-1:0]   op,
  input  logic              wide,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic [RIDX_W-1:0] src_idx,
  output logic              legal,
  output logic              need_write,
  output logic [DATA_W-1:0] new_val,
  output logic              wb_want,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] old_n, src_n, cmp_n, raw;
  logic              match, fetch, is_cas;

  always_comb begin
    keep_mask = wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    old_n     = old_val & keep_mask;
    src_n     = src_val & keep_mask;
    cmp_n     = cmp_val & keep_mask;
    match     = (old_n == cmp_n);
    raw       = '0;
    fetch     = 1'b0;
    is_cas    = 1'b0;
    legal     = 1'b1;
    case (op)
      OP_W'(AMO_ADD), OP_W'(AMO_LADD): raw = old_n + src_n;
      OP_W'(AMO_OR):   raw = old_n | src_n;
      OP_W'(AMO_AND):  raw = old_n & src_n;
      OP_W'(AMO_XOR):  raw = old_n ^ src_n;
      OP_W'(AMO_FADD): begin raw = old_n + src_n; fetch = 1'b1; end
      OP_W'(AMO_FOR):  begin raw = old_n | src_n; fetch = 1'b1; end
      OP_W'(AMO_FAND): begin raw = old_n & src_n; fetch = 1'b1; end
      OP_W'(AMO_FXOR): begin raw = old_n ^ src_n; fetch = 1'b1; end
      OP_W'(AMO_XCHG): begin raw = src_n; fetch = 1'b1; end
      OP_W'(AMO_CAS):  begin raw = src_n; is_cas = 1'b1; end
      default:         legal = 1'b0;
    endcase
    new_val    = raw & keep_mask;
    need_write = is_cas ? match : 1'b1;
    wb_want    = fetch | is_cas;
    wb_reg     = is_cas ? '0 : src_idx;
    wb_data    = old_n;
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fault,
  input  logic       need_write,
  input  logic       mem_ready,
  output amo_state_e state,
  output logic       accept,
  output logic       capture
);
  amo_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    accept    = 1'b0;
    capture   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          accept    = 1'b1;
          state_nxt = fault ? ST_DONE : ST_READ;
        end
      end
      ST_READ: begin
        if (mem_ready) begin
          capture   = 1'b1;
          state_nxt = ST_CALC;
        end
      end
      ST_CALC:  state_nxt = need_write ? ST_WRITE : ST_DONE;
      ST_WRITE: if (mem_ready) state_nxt = ST_DONE;
      ST_DONE:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int OFS_W  = 16,
  parameter int RIDX_W = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] src_val,
  input  logic [DATA_W-1:0] r0_val,
  input  logic [RIDX_W-1:0] src_idx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [DATA_W-1:0] wb_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // command inputs of the address generator and decode are taken from the port side
  logic [ADDR_W-1:0] ea;
  logic              misaligned;

  amo_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_agen (
    .base       (base),
    .ofs        (ofs),
    .wide       (wide),
    .addr       (ea),
    .misaligned (misaligned)
  );

  // latched command
  logic [OP_W-1:0]   op_q;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, cmp_q, old_q;
  logic [RIDX_W-1:0] idx_q;
  logic              err_q;

  // decode of the incoming opcode for legality only
  logic              in_legal;
  logic              in_nw_unused;
  logic [DATA_W-1:0] in_nv_unused, in_wbd_unused;
  logic              in_wbw_unused;
  logic [RIDX_W-1:0] in_wbr_unused;

  amo_alu #(.DATA_W(DATA_W), .OP_W(OP_W), .RIDX_W(RIDX_W)) u_dec (
    .op         (op),
    .wide       (wide),
    .old_val    ('0),
    .src_val    ('0),
    .cmp_val    ('0),
    .src_idx    ('0),
    .legal      (in_legal),
    .need_write (in_nw_unused),
    .new_val    (in_nv_unused),
    .wb_want    (in_wbw_unused),
    .wb_reg     (in_wbr_unused),
    .wb_data    (in_wbd_unused)
  );

  logic              fault;
  logic              alu_legal, need_write, wb_want;
  logic [DATA_W-1:0] new_val, alu_wb_data;
  logic [RIDX_W-1:0] alu_wb_reg;

  assign fault = misaligned | ~in_legal;

  amo_alu #(.DATA_W(DATA_W), .OP_W(OP_W), .RIDX_W(RIDX_W)) u_alu (
    .op         (op_q),
    .wide       (wide_q),
    .old_val    (old_q),
    .src_val    (src_q),
    .cmp_val    (cmp_q),
    .src_idx    (idx_q),
    .legal      (alu_legal),
    .need_write (need_write),
    .new_val    (new_val),
    .wb_want    (wb_want),
    .wb_reg     (alu_wb_reg),
    .wb_data    (alu_wb_data)
  );

  amo_state_e state;
  logic       accept, capture;

  amo_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (start),
    .fault      (fault),
    .need_write (need_write),
    .mem_ready  (mem_ready),
    .state      (state),
    .accept     (accept),
    .capture    (capture)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q   <= '0;
      wide_q <= 1'b0;
      addr_q <= '0;
      src_q  <= '0;
      cmp_q  <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      op_q   <= op;
      wide_q <= wide;
      addr_q <= ea;
      src_q  <= src_val;
      cmp_q  <= r0_val;
      idx_q  <= src_idx;
      err_q  <= fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     old_q <= '0;
    else if (capture) old_q <= mem_rdata;
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    done      = (state == ST_DONE);
    err       = done & err_q;
    wb_en     = done & ~err_q & alu_legal & wb_want;
    wb_reg    = alu_wb_reg;
    wb_data   = alu_wb_data;
    mem_req   = (state == ST_READ) | (state == ST_WRITE);
    mem_we    = (state == ST_WRITE);
    mem_size  = wide_q;
    mem_addr  = addr_q;
    mem_wdata = new_val;
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int RIDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wb_en,
  input logic [RIDX_W-1:0] wb_reg,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  localparam int HALF_W = DATA_W / 2;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done && !wb_en)); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done); // R9

  AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !wb_en); // R10

  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size ? (mem_addr[2:0] == 3'b000) : (mem_addr[1:0] == 2'b00))); // R10

  AST_NARROW_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_size) |-> (mem_wdata[DATA_W-1:HALF_W] == '0)); // R7

  AST_WRITE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(!mem_req)); // R9
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .wb_en     (wb_en),
  .wb_reg    (wb_reg),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  op;
  logic        wide;
  logic [63:0] base;
  logic [15:0] ofs;
  logic [63:0] src_val, r0_val;
  logic [3:0]  src_idx;
  logic        busy, done, err, wb_en;
  logic [3:0]  wb_reg;
  logic [63:0] wb_data;
  logic        mem_req, mem_we, mem_size;
  logic [63:0] mem_addr, mem_wdata;
  logic [63:0] mem_rdata;
  logic        mem_ready;

  int tests = 0;
  int fails = 0;

  amo_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .base(base), .ofs(ofs), .src_val(src_val), .r0_val(r0_val), .src_idx(src_idx),
    .busy(busy), .done(done), .err(err), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  // device memory (what the unit sees) and reference memory (what it should become)
  logic [7:0] dev_mem [longint unsigned];
  logic [7:0] ref_mem [longint unsigned];

  function automatic logic [63:0] dev_rd(input logic [63:0] a, input bit w);
    logic [63:0] v = '0;
    for (int i = 0; i < (w ? 8 : 4); i++)
      if (dev_mem.exists(a + 64'(i))) v[i*8 +: 8] = dev_mem[a + 64'(i)];
    return v;
  endfunction

  function automatic logic [63:0] ref_rd(input logic [63:0] a, input bit w);
    logic [63:0] v = '0;
    for (int i = 0; i < (w ? 8 : 4); i++)
      if (ref_mem.exists(a + 64'(i))) v[i*8 +: 8] = ref_mem[a + 64'(i)];
    return v;
  endfunction

  task automatic preload(input logic [63:0] a, input logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      dev_mem[a + 64'(i)] = v[i*8 +: 8];
      ref_mem[a + 64'(i)] = v[i*8 +: 8];
    end
  endtask

  // memory responder: grants after 'lat' waiting cycles, commits writes one negedge later
  int          lat = 0;
  int          wcnt = 0;
  logic [63:0] r_addr, r_wdata;
  logic        r_we, r_sz;

  initial begin
    mem_ready = 1'b0;
    mem_rdata = '0;
  end

  always @(negedge clk) begin
    if (mem_ready) begin
      if (r_we)
        for (int i = 0; i < (r_sz ? 8 : 4); i++) dev_mem[r_addr + 64'(i)] = r_wdata[i*8 +: 8];
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt == lat) begin
        mem_ready = 1'b1;
        r_addr    = mem_addr;
        r_we      = mem_we;
        r_sz      = mem_size;
        r_wdata   = mem_wdata;
        mem_rdata = r_we ? 64'hDEAD_BEEF_DEAD_BEEF : dev_rd(mem_addr, mem_size);
      end else begin
        wcnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one command, compared cycle by cycle against the model timeline
  task automatic run_op(input int opc, input bit w, input logic [63:0] b, input logic [15:0] o,
                        input logic [63:0] s, input logic [63:0] r0, input logic [3:0] idx,
                        input int l, input bit poke, input string tag);
    logic [63:0] ea, msk, old, sn, nv, exp_wb;
    bit          bad, wr, wbe;
    logic [3:0]  wbr;
    int          done_c;
    bit          fin;
    ea  = b + {{48{o[15]}}, o};
    msk = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    bad = (w ? (ea[2:0] != 0) : (ea[1:0] != 0)) || (opc > 10);
    old = bad ? 64'h0 : ref_rd(ea, w);
    sn  = s & msk;
    nv  = '0; wr = 1'b1; wbe = 1'b0; wbr = idx;
    case (opc)
      0, 10: nv = (old + sn) & msk;
      1: nv = old | sn;
      2: nv = old & sn;
      3: nv = old ^ sn;
      4: begin nv = (old + sn) & msk; wbe = 1; end
      5: begin nv = old | sn; wbe = 1; end
      6: begin nv = old & sn; wbe = 1; end
      7: begin nv = old ^ sn; wbe = 1; end
      8: begin nv = sn; wbe = 1; end
      9: begin nv = sn; wbe = 1; wbr = 4'd0; wr = (old == (r0 & msk)); end
      default: ;
    endcase
    exp_wb = old;
    if (bad) begin wr = 1'b0; wbe = 1'b0; end
    done_c = bad ? 1 : (wr ? 4 + 2*l : 3 + l);
    lat = l;

    @(negedge clk);
    start = 1'b1; op = opc[3:0]; wide = w; base = b; ofs = o;
    src_val = s; r0_val = r0; src_idx = idx;
    fin = 1'b0;
    for (int c = 1; c <= 40 && !fin; c++) begin
      bit exp_req, exp_we, exp_done;
      @(negedge clk);
      start = 1'b0;
      if (poke && c == 2) begin start = 1'b1; op = 4'd8; base = b + 64'h40; src_val = ~s; end
      exp_req  = !bad && ((c >= 1 && c <= 1 + l) || (wr && c >= 3 + l && c <= 3 + 2*l));
      exp_we   = !bad && wr && c >= 3 + l && c <= 3 + 2*l;
      exp_done = (c == done_c);
      check(mem_req == exp_req, {tag, " R9 req timing"}, 64'(mem_req), 64'(exp_req));
      check(mem_we == exp_we, {tag, " R9 we timing"}, 64'(mem_we), 64'(exp_we));
      check(done == exp_done, {tag, " R9 done timing"}, 64'(done), 64'(exp_done));
      if (bad) check(mem_req == 1'b0, {tag, " R10 no access"}, 64'(mem_req), 64'd0);
      if (exp_req) begin
        check(mem_addr == ea, {tag, " R1 address"}, mem_addr, ea);
        check(mem_size == w, {tag, " R7 size"}, 64'(mem_size), 64'(w));
      end
      if (exp_we) check(mem_wdata == nv, {tag, " R2 write data"}, mem_wdata, nv);
      if (c == done_c) begin
        fin = 1'b1;
        check(err == bad, {tag, " R10 R11 err"}, 64'(err), 64'(bad));
        check(wb_en == wbe, {tag, " R3 wb_en"}, 64'(wb_en), 64'(wbe));
        if (wbe) begin
          check(wb_reg == wbr, {tag, " R6 wb_reg"}, 64'(wb_reg), 64'(wbr));
          check(wb_data == exp_wb, {tag, " R4 wb_data"}, wb_data, exp_wb);
        end
      end
    end
    if (!fin) check(1'b0, {tag, " R9 done never seen"}, 64'd0, 64'd1);
    @(negedge clk);
    check(busy == 1'b0 && mem_req == 1'b0, {tag, " R9 idle after done"}, 64'(busy), 64'd0);
    if (wr) for (int i = 0; i < (w ? 8 : 4); i++) ref_mem[ea + 64'(i)] = nv[i*8 +: 8];
    if (!bad) begin
      logic [63:0] dv, rv;
      dv = dev_rd(ea & ~64'h7, 1'b1);
      rv = ref_rd(ea & ~64'h7, 1'b1);
      check(dv == rv, {tag, " R2 memory"}, dv, rv);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; wide = 1'b1; base = '0; ofs = '0;
    src_val = '0; r0_val = '0; src_idx = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !wb_en, "R12 in reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !mem_req && !wb_en, "R12 after release", 64'(mem_req), 64'd0);

    preload(64'h1000, 64'h0000_0001_FFFF_FFF0);
    preload(64'h1008, 64'hF0F0_0000_1234_5678);
    preload(64'h1010, 64'h0000_0000_FFFF_FFFF);
    preload(64'h1018, 64'h8000_0000_0000_0001);
    preload(64'h1020, 64'h1111_2222_3333_4444);

    run_op(0, 1, 64'h1000, 16'h0000, 64'h20, 0, 4'd3, 0, 0, "R2 add64");
    run_op(1, 1, 64'h1000, 16'h0008, 64'h0F00_0000_0000_000F, 0, 4'd3, 1, 0, "R2 or64");
    run_op(2, 1, 64'h1010, 16'hFFF8, 64'hFFFF_0000_FFFF_0000, 0, 4'd3, 0, 0, "R1 R2 and64 negofs");
    run_op(3, 1, 64'h1018, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 4'd3, 2, 0, "R2 xor64");
    run_op(4, 1, 64'h1000, 16'h0000, 64'h5, 0, 4'd7, 2, 0, "R3 fadd64");
    run_op(5, 1, 64'h1008, 16'h0000, 64'h1, 0, 4'd2, 0, 0, "R3 for64");
    run_op(6, 1, 64'h1018, 16'h0000, 64'h00FF, 0, 4'd9, 1, 0, "R3 fand64");
    run_op(7, 1, 64'h1020, 16'h0000, 64'hFFFF, 0, 4'd5, 0, 0, "R3 fxor64");
    run_op(8, 1, 64'h1020, 16'h0000, 64'hCAFE, 0, 4'd6, 1, 0, "R4 xchg64");
    run_op(9, 1, 64'h1020, 16'h0000, 64'h7777, 64'hCAFE, 4'd4, 0, 0, "R5 R6 cas64 match");
    run_op(9, 1, 64'h1020, 16'h0000, 64'h9999, 64'hCAFE, 4'd4, 2, 0, "R5 R6 cas64 miss");
    run_op(10, 1, 64'h1008, 16'h0000, 64'h100, 0, 4'd1, 0, 0, "R8 legacy add64");
    run_op(0, 0, 64'h1010, 16'h0000, 64'hFFFF_FFFF_0000_0002, 0, 4'd1, 1, 0, "R7 add32 wrap");
    run_op(10, 0, 64'h1014, 16'h0000, 64'h3, 0, 4'd1, 0, 0, "R8 legacy add32");
    run_op(4, 0, 64'h1018, 16'h0004, 64'h10, 0, 4'd8, 0, 0, "R7 fadd32 upper");
    run_op(9, 0, 64'h1010, 16'h0000, 64'hABCD, 64'hFFFF_0000_0000_0001, 4'd2, 1, 0, "R7 cas32 low match");
    run_op(9, 0, 64'h1000, 16'h0000, 64'h1, 64'h5, 4'd2, 0, 0, "R6 cas32 miss");
    run_op(0, 1, 64'h1004, 16'h0000, 64'h1, 0, 4'd1, 0, 0, "R10 misaligned64");
    run_op(4, 0, 64'h1000, 16'h0002, 64'h1, 0, 4'd1, 0, 0, "R10 misaligned32");
    run_op(13, 1, 64'h1000, 16'h0000, 64'h1, 0, 4'd1, 0, 0, "R11 bad opcode");
    run_op(3, 1, 64'h1008, 16'h0000, 64'hA5A5, 0, 4'd1, 1, 1, "R9 start while busy");
    run_op(8, 1, 64'h1048, 16'h0000, 64'h1, 0, 4'd1, 0, 0, "R9 poke had no effect");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule